// File: doc/BRIEF.md
# NAND Flash Byte-Cycle Sequencer

This block sits on a simple memory-mapped host bus as a slave and drives an 8-bit raw NAND flash bus. A small control register holds the chip-enable, command-latch and address-latch levels. A write to the I/O register starts one latched command or address byte on the flash bus, using the latch levels held in control. Each access to the data window starts one data byte: a write pulses the write strobe, and a read pulses the read strobe and returns the byte on the flash bus.

Software writes control, writes a byte to the I/O register, and then polls status until the flash is ready and the controller is idle. The flash ready/busy pin passes through a two-flop synchronizer before it reaches status. The host bus uses a request/acknowledge handshake. Accesses that arrive while a byte cycle is in flight are held off by keeping the acknowledge low. Status reads are the one exception and are always answered at once.

Top module: `nand_bus_seq`

## Requirements
- R1: During and right after reset the chip enable is deasserted (nand_ce_no=1), both strobes are high, the data bus is not driven, control reads back 0x01 and the status busy and complete bits are 0.
- R2: A write to any even offset 0x800..0x80E stores wdata_i[4:0] in control, readable at any even offset with bits 7:5 reading 0. Bit 0 drives nand_ce_no directly, with 1 meaning deselected and 0 selecting the flash. Bit 1 is the command latch, bit 2 is the address latch, and bits 3 and 4 are stored only.
- R3: A write to any odd offset 0x801..0x80F starts a byte cycle using control bits 1 and 2 as the latch levels. There is one setup clock with the write strobe high, then T_LOW clocks with it low, then T_HIGH clocks high. wdata_i is driven with nand_d_oe_o=1 from the setup clock through the first high clock.
- R4: A write to offsets 0x000..0x7FF runs the same write cycle with both latch lines at 0, whatever control holds.
- R5: A read of offsets 0x000..0x7FF runs one setup clock, then T_LOW clocks of read strobe low, then T_HIGH clocks high, and does not drive the bus. The byte on nand_d_i at the read strobe's rising edge is returned, and the acknowledge comes only after the cycle has ended.
- R6: Status at offset 0x810 reads bit 3 flash ready, bit 2 controller busy, bit 1 cycle complete and bit 0 always 0, with bits 7:4 equal to 0.
- R7: Busy lasts 1+T_LOW+T_HIGH clocks from the start of a cycle. Status reads are acknowledged while busy, and every other access is stalled until busy is clear.
- R8: The complete bit sets when a byte cycle ends and clears when the next cycle starts.
- R9: The flash ready bit follows nand_rb_i two clocks later.
- R10: The write and read strobes are never low together, and both latch lines hold steady while a strobe is low.
- R11: Offsets 0x811..0xFFF are acknowledged at once. Writes there change nothing and start no cycle, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the window |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | Access completes at the clock edge where this is 1 |
| rdata_o | output | 8 | Read data, valid while ack_o is 1 |
| nand_ce_no | output | 1 | Flash chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_d_o | output | 8 | Flash data out |
| nand_d_oe_o | output | 1 | Flash data output enable |
| nand_d_i | input | 8 | Flash data in |
| nand_rb_i | input | 1 | Flash ready (1) / busy (0) |

## Verification
Counting from the clock edge that accepts a write, the setup clock is seen in the half cycle after that edge. The write strobe is low in the next T_LOW half-cycle samples, and busy is gone 1+T_LOW+T_HIGH edges later. A following access therefore waits exactly that many low-phase samples before it is acknowledged, and a data read waits one more because its own start costs one sample. A change on the ready pin first shows in status at the second falling-edge sample after it. The bench drives at falling edges and samples 1 ns later at each falling edge, so every expected value sits at a known sample index counted from the accepting edge.

// File: rtl/nand_bus_seq_pkg.sv
`timescale 1ns/1ps
package nand_bus_seq_pkg;
  typedef enum logic [2:0] {
    ACC_DATA, ACC_CTL, ACC_IO, ACC_STS, ACC_NONE
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH
  } strobe_st_e;
endpackage

// File: rtl/nand_bus_seq_decode.sv
`timescale 1ns/1ps
module nand_bus_seq_decode
  import nand_bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_BYTES = 2048
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o
);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(DATA_BYTES);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(DATA_BYTES + 16);

  always_comb begin
    if (addr_i < REG_BASE)                          kind_o = ACC_DATA;
    else if (addr_i[ADDR_W-1:4] == REG_BASE[ADDR_W-1:4])
      kind_o = addr_i[0] ? ACC_IO : ACC_CTL;
    else if (addr_i == STS_ADDR)                    kind_o = ACC_STS;
    else                                            kind_o = ACC_NONE;
  end
endmodule

// File: rtl/nand_bus_seq_sync.sv
`timescale 1ns/1ps
module nand_bus_seq_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/nand_bus_seq_strobe.sv
`timescale 1ns/1ps
module nand_bus_seq_strobe
  import nand_bus_seq_pkg::*;
#(
  parameter int T_LOW  = 2,
  parameter int T_HIGH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] nand_d_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_o,
  output logic       we_no,
  output logic       re_no,
  output logic       cle_o,
  output logic       ale_o,
  output logic [7:0] d_o,
  output logic       d_oe_o,
  output logic [7:0] cap_o
);
  localparam int MAXT  = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(T_LOW - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(T_HIGH - 1);

  strobe_st_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q, cle_q, ale_q;
  logic [7:0]       d_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b0;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
      d_q   <= '0;
      cap_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SETUP;
          rd_q  <= rd_i;
          cle_q <= cle_i;
          ale_q <= ale_i;
          d_q   <= wdata_i;
        end
        ST_SETUP: begin
          st_q  <= ST_LOW;
          cnt_q <= LOW_LAST;
        end
        ST_LOW: if (cnt_q == '0) begin
          st_q  <= ST_HIGH;
          cnt_q <= HIGH_LAST;
          if (rd_q) cap_q <= nand_d_i;  // sample at strobe rise
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_HIGH: if (cnt_q == '0) st_q <= ST_IDLE;
                 else             cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic low;
  assign low    = (st_q == ST_LOW);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_HIGH) && (cnt_q == '0);
  assign rd_o   = rd_q;
  assign we_no  = !(low && !rd_q);
  assign re_no  = !(low && rd_q);
  assign cle_o  = cle_q;
  assign ale_o  = ale_q;
  assign d_o    = d_q;
  // hold data one clock past the write strobe rise
  assign d_oe_o = !rd_q && ((st_q == ST_SETUP) || low ||
                            ((st_q == ST_HIGH) && (cnt_q == HIGH_LAST)));
  assign cap_o  = cap_q;
endmodule

// File: rtl/nand_bus_seq.sv
`timescale 1ns/1ps
module nand_bus_seq
  import nand_bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_BYTES = 2048,
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              ack_o,
  output logic [7:0]        rdata_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_d_o,
  output logic              nand_d_oe_o,
  input  logic [7:0]        nand_d_i,
  input  logic              nand_rb_i
);
  localparam int CTL_W = 5;

  acc_kind_e        kind;
  logic [CTL_W-1:0] ctl_q;
  logic             cmd_done_q, rd_done_q;
  logic             busy, done, cyc_rd, rdy_s;
  logic             s_cle, s_ale;
  logic [7:0]       cap;
  logic             launch, data_rd, is_io;

  nand_bus_seq_decode #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) i_decode (
    .addr_i (addr_i),
    .kind_o (kind)
  );

  nand_bus_seq_sync i_rb_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nand_rb_i),
    .q_o    (rdy_s)
  );

  assign is_io   = (kind == ACC_IO);
  assign data_rd = (kind == ACC_DATA) && !we_i;
  assign launch  = req_i && !busy &&
                   ((is_io && we_i) || ((kind == ACC_DATA) && (we_i || !rd_done_q)));
  assign ack_o   = req_i && ((kind == ACC_STS) || (!busy && !(data_rd && !rd_done_q)));

  nand_bus_seq_strobe #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) i_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (launch),
    .rd_i     (!we_i),
    .cle_i    (is_io && ctl_q[1]),
    .ale_i    (is_io && ctl_q[2]),
    .wdata_i  (wdata_i),
    .nand_d_i (nand_d_i),
    .busy_o   (busy),
    .done_o   (done),
    .rd_o     (cyc_rd),
    .we_no    (nand_we_no),
    .re_no    (nand_re_no),
    .cle_o    (s_cle),
    .ale_o    (s_ale),
    .d_o      (nand_d_o),
    .d_oe_o   (nand_d_oe_o),
    .cap_o    (cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= CTL_W'(1);
      cmd_done_q <= 1'b0;
      rd_done_q  <= 1'b0;
    end else begin
      if (ack_o && we_i && (kind == ACC_CTL)) ctl_q <= wdata_i[CTL_W-1:0];
      if (launch)    cmd_done_q <= 1'b0;
      else if (done) cmd_done_q <= 1'b1;
      if (done && cyc_rd)          rd_done_q <= 1'b1;
      else if (ack_o && data_rd)   rd_done_q <= 1'b0;
    end
  end

  assign nand_ce_no = ctl_q[0];
  assign nand_cle_o = busy ? s_cle : ctl_q[1];
  assign nand_ale_o = busy ? s_ale : ctl_q[2];

  always_comb begin
    case (kind)
      ACC_STS:  rdata_o = {4'b0, rdy_s, busy, cmd_done_q, 1'b0};
      ACC_CTL:  rdata_o = {{(8-CTL_W){1'b0}}, ctl_q};
      ACC_DATA: rdata_o = rd_done_q ? cap : 8'h00;
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_bus_seq_chk.sv
`timescale 1ns/1ps
module nand_bus_seq_chk #(
  parameter int ADDR_W     = 12,
  parameter int DATA_BYTES = 2048
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ack_o,
  input logic              nand_we_no,
  input logic              nand_re_no,
  input logic              nand_d_oe_o,
  input logic              nand_cle_o,
  input logic              nand_ale_o,
  input logic              nand_rb_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              rdy_i
);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(DATA_BYTES + 16);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(DATA_BYTES);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  assert_strobes_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  assert_latch_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |=> ($stable(nand_cle_o) && $stable(nand_ale_o)));

  assert_data_driven_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> nand_d_oe_o);

  assert_data_write_launch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && we_i && (addr_i < REG_BASE)) |=>
      (nand_d_oe_o && nand_we_no && !nand_cle_o && !nand_ale_o));

  assert_stall_while_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ack_o) |-> (addr_i == STS_ADDR));

  assert_done_on_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  assert_rb_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (rdy_i == $past(nand_rb_i, 2)));
endmodule

bind nand_bus_seq nand_bus_seq_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .ack_o       (ack_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no),
  .nand_d_oe_o (nand_d_oe_o),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_rb_i   (nand_rb_i),
  .busy_i      (busy),
  .done_i      (cmd_done_q),
  .rdy_i       (rdy_s)
);

// File: tb/test_nand_bus_seq.sv
`timescale 1ns/1ps
module test_nand_bus_seq;
  localparam int TL  = 2;
  localparam int TH  = 2;
  localparam int CYC = 1 + TL + TH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, nd_i = '0;
  logic rb = 1'b1;
  logic ack, ce_n, cle, ale, we_n, re_n, oe;
  logic [7:0] rdata, d_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  nand_bus_seq i_nand_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .nand_ce_no(ce_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_d_o(d_o), .nand_d_oe_o(oe), .nand_d_i(nd_i), .nand_rb_i(rb)
  );

  // {data_win, ctl[4:0], off[3:0], wdata[7:0], exp_cle, exp_ale}
  localparam logic [19:0] VEC [4] = '{
    {1'b0, 5'h02, 4'h1, 8'h90, 1'b1, 1'b0},
    {1'b0, 5'h04, 4'hF, 8'h3C, 1'b0, 1'b1},
    {1'b0, 5'h1C, 4'h7, 8'hA5, 1'b0, 1'b1},
    {1'b1, 5'h02, 4'h5, 8'h5A, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [7:0] wd,
                     output logic [7:0] rd, output int st);
    st = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = wd;
    #1;
    while (!ack) begin
      st++;
      @(negedge clk);
      #1;
    end
    rd = rdata;
    @(posedge clk);
    #2 req = 1'b0; we = 1'b0;
  endtask

  // samples the CYC half-cycles after an accepted write
  task automatic mon_wr(input string tag, input logic ecle, input logic eale, input logic [7:0] ed);
    logic [7:0] ow = '0, oo = '0, ew = '0, eo = '0;
    logic lcle = 1'b0, lale = 1'b0;
    logic [7:0] ld = '0;
    for (int i = 0; i < CYC; i++) begin
      @(negedge clk); #1;
      ow[i] = we_n; oo[i] = oe;
      ew[i] = !(i >= 1 && i <= TL);
      eo[i] = (i <= TL + 1);
      if (i == 1) begin lcle = cle; lale = ale; ld = d_o; end
    end
    chk({tag, " R3 we strobe pattern"}, ow, ew);
    chk({tag, " R3 data enable window"}, oo, eo);
    chk({tag, " R3/R4 latch levels"}, {lcle, lale}, {ecle, eale});
    chk({tag, " R3 data byte"}, ld, ed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int st;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ce_n/we_n/re_n/oe in reset", {ce_n, we_n, re_n, oe}, 4'b1110);
    rst_n = 1'b1;
    bus(1'b0, 12'h802, 8'h00, rd, st);
    chk("R1 control after reset", rd, 8'h01);
    bus(1'b0, 12'h810, 8'h00, rd, st);
    chk("R1 status busy/done after reset", rd & 8'h07, 8'h00);

    // vector table: control write, mirror read, one byte cycle, status
    foreach (VEC[k]) begin
      logic [19:0] v;
      logic [4:0] c;
      logic [3:0] off;
      v = VEC[k];
      c = v[18:14];
      off = v[13:10];
      bus(1'b1, 12'h800 | {8'h0, off & 4'hE}, {3'b111, c}, rd, st);
      bus(1'b0, 12'h808, 8'h00, rd, st);
      chk($sformatf("vec%0d R2 control mirror readback", k), rd, {3'b0, c});
      chk($sformatf("vec%0d R2 ce_n follows bit0", k), ce_n, c[0]);
      if (v[19]) bus(1'b1, {1'b0, off, 7'h11}, v[9:2], rd, st);
      else       bus(1'b1, 12'h800 | {8'h0, off}, v[9:2], rd, st);
      mon_wr($sformatf("vec%0d", k), v[1], v[0], v[9:2]);
      bus(1'b0, 12'h810, 8'h00, rd, st);
      chk($sformatf("vec%0d R6/R8 status after cycle", k), rd, 8'h0A);
    end

    // R7/R8: status while busy, then stall of a following access
    bus(1'b1, 12'h800, 8'h00, rd, st);
    bus(1'b1, 12'h801, 8'h70, rd, st);
    bus(1'b0, 12'h810, 8'h00, rd, st);
    chk("R7 status read not stalled", st, 0);
    chk("R6/R8 status while busy", rd, 8'h0C);
    bus(1'b1, 12'h801, 8'h00, rd, st);
    chk("R7 stall cycles for io write", st, CYC - 1);
    repeat (CYC + 1) @(negedge clk);

    // R5: data read
    nd_i = 8'hC3;
    fork
      bus(1'b0, 12'h123, 8'h00, rd, st);
      begin
        int lows = 0, wlows = 0, oes = 0;
        for (int i = 0; i < CYC + 2; i++) begin
          @(negedge clk); #1;
          if (!re_n) lows++;
          if (!we_n) wlows++;
          if (oe) oes++;
        end
        chk("R5 read strobe low clocks", lows, TL);
        chk("R10 no write strobe on read", wlows, 0);
        chk("R5 bus not driven on read", oes, 0);
      end
    join
    chk("R5 read data", rd, 8'hC3);
    chk("R5 read ack after cycle", st, CYC + 1);

    // R9: ready pin synchronizer latency
    @(negedge clk);
    rb = 1'b0; req = 1'b1; we = 1'b0; addr = 12'h810;
    #1 chk("R9 ready unchanged at once", rdata[3], 1'b1);
    @(negedge clk); #1 chk("R9 ready unchanged after 1 clock", rdata[3], 1'b1);
    @(negedge clk); #1 chk("R9 ready low after 2 clocks", rdata[3], 1'b0);
    req = 1'b0;
    rb = 1'b1;
    repeat (3) @(negedge clk);

    // R11: unmapped offsets
    bus(1'b1, 12'h804, 8'h06, rd, st);
    bus(1'b1, 12'h900, 8'hFF, rd, st);
    chk("R11 unmapped write acked at once", st, 0);
    #3 chk("R11 no strobe after unmapped write", {we_n, oe}, 2'b10);
    bus(1'b0, 12'h900, 8'h00, rd, st);
    chk("R11 unmapped read is zero", rd, 8'h00);
    bus(1'b0, 12'h80C, 8'h00, rd, st);
    chk("R11 control untouched", rd, 8'h06);
    bus(1'b0, 12'h811, 8'h00, rd, st);
    chk("R11 read just past status is zero", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule